// File: doc/BRIEF.md
# Configurable Async Serial Frame Formatter

This block converts bytes to and from asynchronous serial frames. A frame starts with a low start bit. Seven or eight data bits follow, then an optional even or odd parity bit, then a single high stop bit. The line rests high between frames.

A small mode register sets three things: the order of the data bits, whether the data bits are complemented, and whether both paths are held off. The frame length and the parity setup come in on separate static configuration pins.

Both paths are timed by one oversampling enable, `bit_tick`, which pulses OVS times per bit period. The transmitter has a one-byte holding register. It takes a new byte only between frames. The receiver finds the start edge, samples every bit at mid-bit, and reports the byte together with parity and framing error flags.

Top module: `ser_frame_fmt`

## Requirements
- R1: The mode register is read at `reg_rdata`. Bit 3 is the order bit, bit 2 is the invert bit and bit 0 is the hold-off bit. All three are loaded from `reg_wdata` on a cycle with `reg_we`. Bits 7..4 and bit 1 always read 1 and are not changed by writes. After reset the register reads 0xF2.
- R2: `txd` idles at 1. A transmitted frame is a 0 start bit, then the data bits, then the parity bit when `cfg_par_en` is 1, then a 1 stop bit. Every bit holds for exactly OVS `bit_tick` pulses.
- R3: With 8-bit data (`cfg_seven`=0), order bit 0 means bit 0 of the byte is sent first and the first received bit is stored in bit 0. Order bit 1 means bit 7 is sent first and the first received bit is stored in bit 7.
- R4: With 7-bit data (`cfg_seven`=1), only bits 6..0 are sent, always bit 0 first, whatever the order bit says. A received byte is stored in bits 6..0 in arrival order, and bit 7 of `rx_data` is 0.
- R5: When the invert bit is 1, the data bits are complemented before they are sent, and the received data bits are complemented before they are stored. The parity bit on the line is never complemented.
- R6: The parity bit is the XOR of the data bits as they appear on the line, XORed with `cfg_par_odd`. Even parity is `cfg_par_odd`=0.
- R7: `rx_perr` is 1 with `rx_valid` when `cfg_par_en`=1 and the received parity bit differs from the XOR of the received line data bits XORed with `cfg_par_odd`. Without parity it is 0.
- R8: `rx_valid` pulses for one cycle at the mid-bit sample of the stop bit. At that point `rx_ferr` shows whether the stop bit was sampled as 0.
- R9: `tx_ready` is 1 exactly when the holding register is empty. A `tx_load` pulse while `tx_ready`=0 is ignored. A held byte moves into the shifter only on a `bit_tick` while no frame is being sent.
- R10: While the hold-off bit is 1, the transmitter starts no frame, so `txd` stays 1 and a held byte stays held. The receiver also ignores start edges while the bit is 1.
- R11: A low pulse on `rxd` that reads high again at the mid-bit sample of the start bit produces no `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | Oversampling enable, OVS pulses per bit |
| reg_we | input | 1 | Mode register write strobe |
| reg_wdata | input | 8 | Mode register write data |
| reg_rdata | output | 8 | Mode register read value |
| cfg_seven | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| tx_data | input | 8 | Byte to transmit |
| tx_load | input | 1 | Load strobe for `tx_data` |
| tx_ready | output | 1 | Holding register empty |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle received-byte pulse |
| rx_perr | output | 1 | Parity error, valid with `rx_valid` |
| rx_ferr | output | 1 | Framing error, valid with `rx_valid` |

## Verification
The bench builds the block with OVS=8, the smallest value that still puts each mid-bit sample well inside a bit. It pulses `bit_tick` every third clock. These settings keep a frame near 260 cycles, so all the combinations of order, invert, 7 or 8 bits and parity fit in one run, and so do the hold-off, glitch and bad-stop cases. The synchronizer delay and the tick phase are visible in this setup, and together they test the sampling margin at the start edge.

// File: rtl/ser_frame_fmt.sv
module ser_frame_fmt #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       cfg_seven,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic [7:0] tx_data,
  input  logic       tx_load,
  output logic       tx_ready,
  output logic       txd,
  input  logic       rxd,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_perr,
  output logic       rx_ferr
);
  localparam int PW = $clog2(OVS);
  localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);
  localparam logic [PW-1:0] PH_MID = PW'(OVS / 2 - 1);

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  logic m_dir, m_inv, m_imode;
  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[7:4], reg_wdata[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_dir <= 1'b0;
      m_inv <= 1'b0;
      m_imode <= 1'b0;
    end else if (reg_we) begin
      m_dir <= reg_wdata[3];
      m_inv <= reg_wdata[2];
      m_imode <= reg_wdata[0];
    end
  end

  assign reg_rdata = {4'hF, m_dir, m_inv, 1'b1, m_imode};

  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_we) |-> $stable(reg_rdata));

  logic [3:0] last_ix;
  assign last_ix = (cfg_seven ? 4'd8 : 4'd9) + {3'b000, cfg_par_en};

  logic [7:0] hold;
  logic hold_full;
  logic [7:0] tx_inv, tx_ord;
  logic tx_par;
  logic [10:0] frm_n;
  logic tx_busy;
  logic [10:0] tx_frm;
  logic [3:0] tx_bidx, tx_last;
  logic [PW-1:0] tx_ph;

  assign tx_inv = m_inv ? ~hold : hold;
  assign tx_ord = cfg_seven ? {1'b0, tx_inv[6:0]} : (m_dir ? rev8(tx_inv) : tx_inv);
  assign tx_par = (cfg_seven ? ^tx_inv[6:0] : ^tx_inv) ^ cfg_par_odd;

  always_comb begin
    frm_n = '1;
    frm_n[0] = 1'b0;
    if (cfg_seven) begin
      frm_n[7:1] = tx_ord[6:0];
      if (cfg_par_en) frm_n[8] = tx_par;
    end else begin
      frm_n[8:1] = tx_ord;
      if (cfg_par_en) frm_n[9] = tx_par;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
      hold_full <= 1'b0;
      tx_busy <= 1'b0;
      tx_frm <= '1;
      tx_bidx <= '0;
      tx_last <= '0;
      tx_ph <= '0;
    end else begin
      if (tx_load && !hold_full) begin
        hold <= tx_data;
        hold_full <= 1'b1;
      end
      if (bit_tick) begin
        if (tx_busy) begin
          if (tx_ph == PH_LAST) begin
            tx_ph <= '0;
            if (tx_bidx == tx_last) tx_busy <= 1'b0;
            else tx_bidx <= tx_bidx + 4'd1;
          end else begin
            tx_ph <= tx_ph + 1'b1;
          end
        end else if (hold_full && !m_imode) begin
          tx_busy <= 1'b1;
          tx_frm <= frm_n;
          tx_last <= last_ix;
          tx_bidx <= '0;
          tx_ph <= '0;
          hold_full <= 1'b0;
        end
      end
    end
  end

  assign txd = tx_busy ? tx_frm[tx_bidx] : 1'b1;
  assign tx_ready = !hold_full;

  p_load_fills_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && tx_ready |=> !tx_ready);
  p_start_needs_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(hold_full) && !$past(m_imode));
  p_start_bit_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);

  logic rx_s1, rx_s, rx_prev, rx_busy;
  logic [PW-1:0] rx_ph;
  logic [3:0] rx_bidx;
  logic [8:0] rx_raw;
  logic [7:0] rx_byte;
  logic rx_pbit, rx_pcalc;

  assign rx_byte = cfg_seven ? {1'b0, rx_raw[6:0] ^ {7{m_inv}}}
                             : ((m_dir ? rev8(rx_raw[7:0]) : rx_raw[7:0]) ^ {8{m_inv}});
  assign rx_pbit = cfg_seven ? rx_raw[7] : rx_raw[8];
  assign rx_pcalc = (cfg_seven ? ^rx_raw[6:0] : ^rx_raw[7:0]) ^ cfg_par_odd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s <= 1'b1;
      rx_prev <= 1'b0;
      rx_busy <= 1'b0;
      rx_ph <= '0;
      rx_bidx <= '0;
      rx_raw <= '0;
      rx_data <= '0;
      rx_valid <= 1'b0;
      rx_perr <= 1'b0;
      rx_ferr <= 1'b0;
    end else begin
      rx_s1 <= rxd;
      rx_s <= rx_s1;
      rx_valid <= 1'b0;
      if (bit_tick) begin
        rx_prev <= rx_s;
        if (!rx_busy) begin
          if (rx_prev && !rx_s && !m_imode) begin
            rx_busy <= 1'b1;
            rx_ph <= '0;
            rx_bidx <= '0;
          end
        end else begin
          rx_ph <= rx_ph + 1'b1;
          if (rx_ph == PH_MID) begin
            if (rx_bidx == 4'd0) begin
              if (rx_s) rx_busy <= 1'b0;
              else rx_bidx <= 4'd1;
            end else if (rx_bidx == last_ix) begin
              rx_busy <= 1'b0;
              rx_valid <= 1'b1;
              rx_data <= rx_byte;
              rx_perr <= cfg_par_en && (rx_pbit != rx_pcalc);
              rx_ferr <= !rx_s;
            end else begin
              rx_raw[rx_bidx - 4'd1] <= rx_s;
              rx_bidx <= rx_bidx + 4'd1;
            end
          end
        end
      end
    end
  end

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_perr_needs_par_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !$past(cfg_par_en) |-> !rx_perr);
  p_rx_start_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_busy) |-> !$past(m_imode));
endmodule

// File: tb/test_ser_frame_fmt.sv
module test_ser_frame_fmt;
  localparam int OVS = 8;
  localparam int TK = 3;

  logic clk = 0, rst_n = 0, bit_tick = 0, reg_we = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, tx_data = 0, rx_data;
  logic cfg_seven = 0, cfg_par_en = 0, cfg_par_odd = 0;
  logic tx_load = 0, tx_ready, txd, rxd = 1, rx_valid, rx_perr, rx_ferr;
  int total = 0, bad = 0, tcnt = 0;

  ser_frame_fmt #(.OVS(OVS)) i_ser_frame_fmt (.*);

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tcnt = (tcnt == TK - 1) ? 0 : tcnt + 1;
    bit_tick <= (tcnt == 0);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  int mq[$];
  int hq[$];
  int mcnt = 0;
  bit mdir = 0, minv = 0, mim = 0;

  function automatic void build_frame(input logic [7:0] b);
    logic [7:0] d;
    int n, ones;
    d = minv ? ~b : b;
    n = cfg_seven ? 7 : 8;
    ones = 0;
    mq.push_back(0);
    for (int i = 0; i < n; i++) begin
      int bv;
      bv = (!cfg_seven && mdir) ? int'(d[7-i]) : int'(d[i]);
      ones += bv;
      mq.push_back(bv);
    end
    if (cfg_par_en) mq.push_back((ones % 2) ^ int'(cfg_par_odd));
    mq.push_back(1);
  endfunction

  always @(posedge clk) begin
    bit ld_ok;
    logic [7:0] ld_v;
    if (!rst_n) begin
      mq.delete(); hq.delete(); mcnt = 0; mdir = 0; minv = 0; mim = 0;
    end else begin
      ld_ok = tx_load && (hq.size() == 0);
      ld_v = tx_data;
      if (bit_tick) begin
        if (mq.size() > 0) begin
          mcnt++;
          if (mcnt == OVS) begin
            mcnt = 0;
            void'(mq.pop_front());
          end
        end else if (hq.size() > 0 && !mim) begin
          build_frame(8'(hq.pop_front()));
          mcnt = 0;
        end
      end
      if (ld_ok) hq.push_back(int'(ld_v));
      if (reg_we) begin
        mdir = reg_wdata[3]; minv = reg_wdata[2]; mim = reg_wdata[0];
      end
    end
  end

  int got = 0;
  logic [7:0] g_data;
  logic g_perr, g_ferr;

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2/R3/R4/R5/R6 txd", 32'(txd), mq.size() > 0 ? 32'(mq[0]) : 32'd1);
      chk("R9 tx_ready", 32'(tx_ready), 32'(hq.size() == 0));
      chk("R1 reg_rdata", 32'(reg_rdata), 32'({4'hF, mdir, minv, 1'b1, mim}));
      if (rx_valid) begin
        got++; g_data = rx_data; g_perr = rx_perr; g_ferr = rx_ferr;
      end
    end
  end

  task automatic wr_mode(input logic [7:0] v);
    @(negedge clk); reg_we = 1; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic tx_put(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_load = 1; tx_data = b;
    @(negedge clk); tx_load = 0;
  endtask

  task automatic tx_drain();
    @(negedge clk);
    while (mq.size() > 0 || hq.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic rx_bit(input logic v);
    rxd = v;
    repeat (OVS * TK) @(negedge clk);
  endtask

  task automatic rx_send(input logic [8:0] arr, input int n, input bit wp, input logic pb,
                         input logic stopv);
    rx_bit(0);
    for (int i = 0; i < n; i++) rx_bit(arr[i]);
    if (wp) rx_bit(pb);
    rx_bit(stopv);
    rx_bit(1); rx_bit(1);
  endtask

  task automatic rx_case(input string tag, input logic [8:0] arr, input logic pb, input logic stopv);
    int n, ones, g0;
    logic [7:0] e;
    bit eperr;
    n = cfg_seven ? 7 : 8;
    e = 0; ones = 0;
    for (int i = 0; i < n; i++) begin
      int pos;
      pos = (n == 8 && mdir) ? 7 - i : i;
      e[pos] = arr[i] ^ minv;
      ones += int'(arr[i]);
    end
    eperr = cfg_par_en && (((ones + int'(pb)) % 2) != int'(cfg_par_odd));
    g0 = got;
    rx_send(arr, n, cfg_par_en, pb, stopv);
    chk({tag, " valid count"}, 32'(got - g0), 32'd1);
    chk({tag, " data"}, 32'(g_data), 32'(e));
    chk({tag, " R7 perr"}, 32'(g_perr), 32'(eperr));
    chk({tag, " R8 ferr"}, 32'(g_ferr), 32'(!stopv));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset read", 32'(reg_rdata), 32'hF2);
    chk("R9 reset ready", 32'(tx_ready), 32'd1);
    chk("R2 idle line", 32'(txd), 32'd1);
    wr_mode(8'h00); chk("R1 write zeros", 32'(reg_rdata), 32'hF2);
    wr_mode(8'hFE); chk("R1 write ones", 32'(reg_rdata), 32'hFE);
    wr_mode(8'h00);

    tx_put(8'hA5); tx_put(8'h3C);
    @(negedge clk); tx_load = 1; tx_data = 8'hEE;
    @(negedge clk); tx_load = 0;
    tx_drain();
    wr_mode(8'h08); tx_put(8'h81); tx_put(8'h12); tx_drain();
    cfg_par_en = 1;
    wr_mode(8'h04); tx_put(8'h0F); tx_drain();
    cfg_par_odd = 1; tx_put(8'h55); tx_drain();
    cfg_seven = 1; wr_mode(8'h08); tx_put(8'hD3); tx_drain();
    cfg_seven = 0; cfg_par_en = 0; cfg_par_odd = 0;
    wr_mode(8'h01); tx_put(8'h77);
    repeat (3 * OVS * TK) @(negedge clk);
    chk("R10 line held", 32'(txd), 32'd1);
    chk("R10 byte held", 32'(tx_ready), 32'd0);
    wr_mode(8'h00); tx_drain();

    rx_case("R3 lsb", 9'h0A5, 0, 1);
    wr_mode(8'h08); rx_case("R3 msb", 9'h001, 0, 1);
    cfg_par_en = 1; wr_mode(8'h04);
    rx_case("R5 R6 even ok", 9'h03C, 0, 1);
    rx_case("R7 even bad", 9'h03C, 1, 1);
    cfg_par_odd = 1; rx_case("R7 odd ok", 9'h003, 1, 1);
    cfg_seven = 1; wr_mode(8'h08); rx_case("R4 seven", 9'h045, 0, 1);
    cfg_seven = 0; cfg_par_en = 0; cfg_par_odd = 0; wr_mode(8'h00);
    rx_case("R8 bad stop", 9'h0F0, 0, 0);
    rx_bit(1); rx_bit(1);
    begin
      int g0;
      g0 = got;
      rxd = 0; repeat (TK) @(negedge clk); rxd = 1;
      repeat (3 * OVS * TK) @(negedge clk);
      chk("R11 glitch ignored", 32'(got - g0), 32'd0);
      wr_mode(8'h01);
      g0 = got;
      rx_send(9'h055, 8, 0, 0, 1);
      chk("R10 rx held off", 32'(got - g0), 32'd0);
      wr_mode(8'h00);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule